// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between a set of level-sensitive peripheral interrupt lines and a processor core. Each line carries its own enable bit and a 5-bit priority. A base-priority threshold and a global mask bit add two more filters. Every cycle the block picks the most urgent request that passes all of these filters and presents it as a take request. The take request carries the exception number and the byte address of the matching vector-table slot. A separate non-maskable input bypasses the enables, the threshold and the global mask.

The core accepts a presented request with a one-cycle acknowledge. The block then records that exception as active and pushes the previously active level onto a small nesting stack. While a handler is active, only a strictly more urgent request is presented. A one-cycle return pulse pops the stack and restores the previous active level. Because lines are level sensitive, a peripheral flag that stays set is taken again after the return. Software configures the block through a word-addressed register port with a combinational read path.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all enables, priorities, the threshold and the global mask read as 0, no handler is active and take_req is low.
- R2: Writing to address 0 sets each enable bit whose write-data bit is 1; a 0 bit leaves that enable unchanged; reading address 0 returns the enable bits in [N_LINES-1:0].
- R3: Writing to address 1 clears each enable bit whose write-data bit is 1; reading address 1 also returns the enable bits.
- R4: Address 4+i holds the priority of line i in bits [4:0]; the numerically lowest priority wins, and equal priorities go to the lowest line index.
- R5: Address 2 bits [4:0] hold the threshold; when it is nonzero, a line is taken only if its priority is less than or equal to the threshold; a value of 0 applies no threshold.
- R6: Address 3 bit 0 is the global mask; while it is 1, no peripheral line is presented, but the non-maskable input still is.
- R7: Line i reports exception number 16+i and the non-maskable input reports 2; take_vec equals the exception number times 4 (line 18 gives 34 and 0x88).
- R8: A line is presented only while its input is high and its enable is set; a line held high is presented again after its handler returns.
- R9: take_ack while take_req is high (and ret_pulse is low) makes the presented exception active on the next cycle; while a handler is active, only a priority strictly lower in number is presented, and the non-maskable input preempts any peripheral handler but not itself.
- R10: ret_pulse restores the previously active exception, or idle; a ret_pulse while idle is ignored, and a take_ack in the same cycle as ret_pulse is ignored.
- R11: When NEST_DEPTH handlers are nested, take_req stays low until a return.
- R12: Reads of addresses that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_LINES | Level-sensitive peripheral requests |
| nmi_req | input | 1 | Non-maskable request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| take_req | output | 1 | A request is presented for taking |
| take_exc | output | 8 | Exception number of the presented request |
| take_vec | output | 10 | Vector-table byte address of the presented request |
| take_ack | input | 1 | Core accepts the presented request |
| ret_pulse | input | 1 | Active handler returns |
| active_valid | output | 1 | A handler is active |
| active_exc | output | 8 | Exception number of the active handler |

## Verification
Directed patterns are applied first. Two lines of equal priority separate the tie rule from the priority compare, and a changed priority then shows that the compare really decides the winner. A threshold placed just below and then just at a line's priority shows where the inclusive boundary lies. The global mask combined with the non-maskable input separates masked peripheral lines from the one source that ignores the mask. Nested acknowledges with equal and then lower priority numbers separate strict preemption from equal-level preemption, and four nested handlers followed by a returning, still-pending line exercise the stack limit and level re-triggering. Random traffic then mixes register writes, acknowledges, returns and sparse line patterns against a bench model of the selection rules.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int PRIO_W   = 5;
    localparam int LVL_W    = PRIO_W + 1;
    localparam int EXC_W    = 8;
    localparam int VEC_W    = EXC_W + 2;
    localparam int DATA_W   = 32;

    // register word offsets
    localparam int OFS_EN_SET = 0;
    localparam int OFS_EN_CLR = 1;
    localparam int OFS_BASE   = 2;
    localparam int OFS_GMASK  = 3;
    localparam int OFS_PRIO   = 4;

    localparam logic [EXC_W-1:0] EXC_NMI       = 8'd2;
    localparam logic [EXC_W-1:0] EXC_LINE_BASE = 8'd16;

    // internal urgency level: 0 is the non-maskable source, 1..32 lines, all-ones idle
    localparam logic [LVL_W-1:0] LVL_NMI  = '0;
    localparam logic [LVL_W-1:0] LVL_IDLE = '1;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [EXC_W-1:0] exc;
    } act_t;

    typedef struct packed {
        logic              valid;
        logic [LVL_W-1:0]  lvl;
        logic [EXC_W-1:0]  exc;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    function automatic logic [LVL_W-1:0] line_level(input logic [PRIO_W-1:0] p);
        return {1'b0, p} + LVL_W'(1);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [EXC_W-1:0] exc);
        return {exc, 2'b00};
    endfunction

endpackage

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int REG_AW  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [N_LINES-1:0]  en_q,
    output logic [PRIO_W-1:0]   prio_q [N_LINES],
    output logic [PRIO_W-1:0]   base_q,
    output logic                gmask_q
);

    localparam logic [REG_AW-1:0] A_SET   = REG_AW'(OFS_EN_SET);
    localparam logic [REG_AW-1:0] A_CLR   = REG_AW'(OFS_EN_CLR);
    localparam logic [REG_AW-1:0] A_BASE  = REG_AW'(OFS_BASE);
    localparam logic [REG_AW-1:0] A_GMASK = REG_AW'(OFS_GMASK);

    logic [N_LINES-1:0] wbits;
    assign wbits = reg_wdata[N_LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (reg_wr && reg_addr == A_SET) begin
            en_q <= en_q | wbits;
        end else if (reg_wr && reg_addr == A_CLR) begin
            en_q <= en_q & ~wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            gmask_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_BASE)  base_q  <= reg_wdata[PRIO_W-1:0];
            if (reg_addr == A_GMASK) gmask_q <= reg_wdata[0];
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[i] <= '0;
            end else if (reg_wr && reg_addr == REG_AW'(OFS_PRIO + i)) begin
                prio_q[i] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_SET || reg_addr == A_CLR) begin
            reg_rdata[N_LINES-1:0] = en_q;
        end else if (reg_addr == A_BASE) begin
            reg_rdata[PRIO_W-1:0] = base_q;
        end else if (reg_addr == A_GMASK) begin
            reg_rdata[0] = gmask_q;
        end
        for (int i = 0; i < N_LINES; i++) begin
            if (reg_addr == REG_AW'(OFS_PRIO + i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
        end
    end

endmodule

// File: rtl/ipc_select.sv
module ipc_select
    import ipc_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               nmi_req,
    input  logic [N_LINES-1:0] en_q,
    input  logic [PRIO_W-1:0]  prio_q [N_LINES],
    input  logic [PRIO_W-1:0]  base_q,
    input  logic               gmask_q,
    input  logic [LVL_W-1:0]   act_lvl,
    output cand_t              cand
);

    logic [N_LINES-1:0] elig;

    for (genvar i = 0; i < N_LINES; i++) begin : g_elig
        assign elig[i] = irq_lines[i] & en_q[i] & ~gmask_q
                       & ((base_q == '0) | (prio_q[i] <= base_q))
                       & (line_level(prio_q[i]) < act_lvl);
    end

    always_comb begin
        cand       = '0;
        cand.lvl   = LVL_IDLE;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N_LINES; i++) begin
            if (elig[i] && line_level(prio_q[i]) < cand.lvl) begin
                cand.valid = 1'b1;
                cand.lvl   = line_level(prio_q[i]);
                cand.prio  = prio_q[i];
                cand.exc   = EXC_LINE_BASE + EXC_W'(i);
            end
        end
        if (nmi_req && act_lvl != LVL_NMI) begin
            cand.valid = 1'b1;
            cand.lvl   = LVL_NMI;
            cand.prio  = '0;
            cand.exc   = EXC_NMI;
        end
    end

endmodule

// File: rtl/ipc_nest.sv
module ipc_nest
    import ipc_pkg::*;
#(
    parameter int NEST_DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  act_t push_val,
    output act_t cur_act,
    output logic nest_full
);

    localparam int SP_W  = $clog2(NEST_DEPTH + 1);
    localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

    act_t            stk [NEST_DEPTH];
    logic [SP_W-1:0] sp;
    logic            do_pop, do_push;

    assign nest_full = (sp == SP_W'(NEST_DEPTH));
    assign do_pop    = pop && (sp != '0);
    assign do_push   = push && !pop && !nest_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= '0;
            cur_act <= '{lvl: LVL_IDLE, exc: '0};
        end else if (do_pop) begin
            cur_act <= stk[IDX_W'(sp - SP_W'(1))];
            sp      <= sp - SP_W'(1);
        end else if (do_push) begin
            cur_act <= push_val;
            sp      <= sp + SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) stk[IDX_W'(sp)] <= cur_act;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int N_LINES    = 24,
    parameter int NEST_DEPTH = 4,
    parameter int REG_AW     = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               nmi_req,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               take_req,
    output logic [7:0]         take_exc,
    output logic [9:0]         take_vec,
    input  logic               take_ack,
    input  logic               ret_pulse,
    output logic               active_valid,
    output logic [7:0]         active_exc
);

    logic [N_LINES-1:0] en_q;
    logic [PRIO_W-1:0]  prio_q [N_LINES];
    logic [PRIO_W-1:0]  base_q;
    logic               gmask_q;
    cand_t              cand;
    act_t               cur_act;
    act_t               new_act;
    logic               nest_full;
    logic               accept;

    ipc_regs #(.N_LINES(N_LINES), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .prio_q    (prio_q),
        .base_q    (base_q),
        .gmask_q   (gmask_q)
    );

    ipc_select #(.N_LINES(N_LINES)) u_select (
        .irq_lines (irq_lines),
        .nmi_req   (nmi_req),
        .en_q      (en_q),
        .prio_q    (prio_q),
        .base_q    (base_q),
        .gmask_q   (gmask_q),
        .act_lvl   (cur_act.lvl),
        .cand      (cand)
    );

    assign take_req = cand.valid & ~nest_full;
    assign take_exc = take_req ? cand.exc : '0;
    assign take_vec = vec_of(take_exc);
    assign accept   = take_ack & take_req & ~ret_pulse;
    assign new_act  = '{lvl: cand.lvl, exc: cand.exc};

    ipc_nest #(.NEST_DEPTH(NEST_DEPTH)) u_nest (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .pop       (ret_pulse),
        .push_val  (new_act),
        .cur_act   (cur_act),
        .nest_full (nest_full)
    );

    assign active_valid = (cur_act.lvl != LVL_IDLE);
    assign active_exc   = active_valid ? cur_act.exc : '0;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] irq_lines,
    input logic [N_LINES-1:0] en_q,
    input logic               gmask_q,
    input logic [PRIO_W-1:0]  base_q,
    input cand_t              cand,
    input act_t               cur_act,
    input logic               nest_full,
    input logic               take_req,
    input logic [7:0]         take_exc,
    input logic               take_ack,
    input logic               ret_pulse,
    input logic               active_valid,
    input logic [7:0]         active_exc
);

    logic [EXC_W-1:0] lidx;
    logic             line_live;
    assign lidx      = take_exc - EXC_LINE_BASE;
    assign line_live = |(((irq_lines & en_q) >> lidx) & N_LINES'(1));

    AST_LINE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (take_req && take_exc != EXC_NMI) |-> line_live); // R8

    AST_GMASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (take_req && gmask_q) |-> take_exc == EXC_NMI); // R6

    AST_BASE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (take_req && take_exc != EXC_NMI && base_q != '0) |-> cand.prio <= base_q); // R5

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        take_req |-> cand.lvl < cur_act.lvl); // R9

    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        (take_req && take_ack && !ret_pulse) |=> (active_valid && active_exc == $past(take_exc))); // R9

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        nest_full |-> !take_req); // R11

    AST_EXC_RANGE: assert property (@(posedge clk) disable iff (rst)
        take_req |-> (take_exc == EXC_NMI ||
                      (take_exc >= EXC_LINE_BASE && take_exc < EXC_LINE_BASE + EXC_W'(N_LINES)))); // R7

    AST_IDLE_RET: assert property (@(posedge clk) disable iff (rst)
        (!active_valid && ret_pulse) |=> !active_valid); // R10

endmodule

bind irq_prio_ctrl ipc_checker #(.N_LINES(N_LINES)) u_ipc_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_lines    (irq_lines),
    .en_q         (en_q),
    .gmask_q      (gmask_q),
    .base_q       (base_q),
    .cand         (cand),
    .cur_act      (cur_act),
    .nest_full    (nest_full),
    .take_req     (take_req),
    .take_exc     (take_exc),
    .take_ack     (take_ack),
    .ret_pulse    (ret_pulse),
    .active_valid (active_valid),
    .active_exc   (active_exc)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    localparam int N     = 24;
    localparam int DEPTH = 4;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_lines;
    logic          nmi_req;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          take_req;
    logic [7:0]    take_exc;
    logic [9:0]    take_vec;
    logic          take_ack;
    logic          ret_pulse;
    logic          active_valid;
    logic [7:0]    active_exc;

    irq_prio_ctrl #(.N_LINES(N), .NEST_DEPTH(DEPTH), .REG_AW(AW)) i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi_req(nmi_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .take_req(take_req), .take_exc(take_exc), .take_vec(take_vec),
        .take_ack(take_ack), .ret_pulse(ret_pulse),
        .active_valid(active_valid), .active_exc(active_exc)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    // reference model state
    bit [N-1:0] m_en;
    int         m_prio [N];
    int         m_base, m_gmask;
    int         stk_lvl [DEPTH];
    int         stk_exc [DEPTH];
    int         m_sp, m_act_lvl, m_act_exc;
    bit         exp_valid;
    int         exp_exc, exp_lvl;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 0 || a == 1) return int'(m_en);
        if (a == 2) return m_base;
        if (a == 3) return m_gmask;
        if (a >= 4 && a < 4 + N) return m_prio[a-4];
        return 0;
    endfunction

    task automatic compute_exp();
        int best = 99;
        exp_valid = 0; exp_exc = 0; exp_lvl = 63;
        for (int i = 0; i < N; i++) begin
            if (irq_lines[i] && m_en[i] && m_gmask == 0 &&
                (m_base == 0 || m_prio[i] <= m_base) &&
                (m_prio[i] + 1 < m_act_lvl) && m_prio[i] < best) begin
                best = m_prio[i];
                exp_valid = 1; exp_exc = 16 + i; exp_lvl = m_prio[i] + 1;
            end
        end
        if (nmi_req && m_act_lvl != 0) begin
            exp_valid = 1; exp_exc = 2; exp_lvl = 0;
        end
        if (m_sp == DEPTH) exp_valid = 0;
    endtask

    task automatic model_update();
        if (reg_wr) begin
            case (int'(reg_addr))
                0: m_en = m_en | reg_wdata[N-1:0];
                1: m_en = m_en & ~reg_wdata[N-1:0];
                2: m_base = int'(reg_wdata[4:0]);
                3: m_gmask = int'(reg_wdata[0]);
                default: if (int'(reg_addr) >= 4 && int'(reg_addr) < 4 + N)
                             m_prio[int'(reg_addr) - 4] = int'(reg_wdata[4:0]);
            endcase
        end
        if (ret_pulse) begin
            if (m_sp > 0) begin
                m_sp--;
                m_act_lvl = stk_lvl[m_sp];
                m_act_exc = stk_exc[m_sp];
            end
        end else if (take_ack && exp_valid) begin
            stk_lvl[m_sp] = m_act_lvl;
            stk_exc[m_sp] = m_act_exc;
            m_sp++;
            m_act_lvl = exp_lvl;
            m_act_exc = exp_exc;
        end
    endtask

    // check outputs mid-cycle, then advance one clock and update the model
    task automatic cycle(input string tag);
        #1;
        compute_exp();
        chk(tag, "take_req", 32'(take_req), 32'(exp_valid));
        if (exp_valid) begin
            chk(tag, "take_exc", 32'(take_exc), 32'(exp_exc));
            chk(tag, "take_vec", 32'(take_vec), 32'(exp_exc * 4));
        end
        chk(tag, "active_valid", 32'(active_valid), 32'(m_sp != 0));
        if (m_sp != 0) chk(tag, "active_exc", 32'(active_exc), 32'(m_act_exc));
        @(posedge clk);
        model_update();
        @(negedge clk);
        reg_wr = 0; take_ack = 0; ret_pulse = 0;
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        cycle(tag);
    endtask

    task automatic rd_chk(input int a, input string tag);
        reg_addr = AW'(a);
        #1;
        chk(tag, $sformatf("read addr %0d", a), reg_rdata, 32'(model_read(a)));
    endtask

    task automatic ack(input string tag);
        take_ack = 1;
        cycle(tag);
    endtask

    task automatic ret(input string tag);
        ret_pulse = 1;
        cycle(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired (R1..R12 incomplete)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_en = '0; m_base = 0; m_gmask = 0; m_sp = 0; m_act_lvl = 63; m_act_exc = 0;
        for (int i = 0; i < N; i++) m_prio[i] = 0;
        rst = 1; irq_lines = '0; nmi_req = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        take_ack = 0; ret_pulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state, all lines requesting but none enabled
        irq_lines = '1;
        cycle("R1");
        rd_chk(0, "R1"); rd_chk(2, "R1"); rd_chk(3, "R1"); rd_chk(9, "R1");
        irq_lines = '0;

        // R2: set-enable, zero bits leave state alone
        wr_reg(0, 32'h5, "R2");
        rd_chk(0, "R2");
        wr_reg(0, 32'h0, "R2");
        rd_chk(0, "R2");
        chk("R2", "enable after zero write", reg_rdata, 32'h5);
        // R3: clear-enable
        wr_reg(1, 32'h1, "R3");
        rd_chk(1, "R3");
        chk("R3", "enable after clear", reg_rdata, 32'h4);
        wr_reg(1, 32'hFFFF_FFFF, "R3");

        // R7: line 18 gives exception 34, vector 0x88
        wr_reg(0, 32'h1 << 18, "R7");
        irq_lines = N'(1) << 18;
        #1;
        chk("R7", "exc line18", 32'(take_exc), 32'd34);
        chk("R7", "vec line18", 32'(take_vec), 32'h88);
        cycle("R7");
        irq_lines = '0;
        wr_reg(1, 32'h1 << 18, "R8");
        irq_lines = N'(1) << 18;
        cycle("R8");
        irq_lines = '0;

        // R4: equal priority goes to lowest line, then priority decides
        wr_reg(0, 32'h28, "R4");
        wr_reg(4 + 3, 32'd7, "R4");
        wr_reg(4 + 5, 32'd7, "R4");
        irq_lines = N'(32'h28);
        #1; chk("R4", "tie exc", 32'(take_exc), 32'd19);
        cycle("R4");
        wr_reg(4 + 3, 32'd9, "R4");
        #1; chk("R4", "prio exc", 32'(take_exc), 32'd21);
        cycle("R4");
        rd_chk(4 + 3, "R4");

        // R5: threshold boundary, zero disables it
        wr_reg(4 + 5, 32'd10, "R5");
        wr_reg(2, 32'd8, "R5");
        #1; chk("R5", "below threshold", 32'(take_req), 32'd0);
        cycle("R5");
        wr_reg(2, 32'd9, "R5");
        #1; chk("R5", "at threshold", 32'(take_exc), 32'd19);
        cycle("R5");
        rd_chk(2, "R5");
        wr_reg(2, 32'd0, "R5");
        cycle("R5");

        // R6: global mask versus non-maskable input
        wr_reg(3, 32'd1, "R6");
        #1; chk("R6", "masked", 32'(take_req), 32'd0);
        cycle("R6");
        nmi_req = 1;
        #1; chk("R6", "nmi exc", 32'(take_exc), 32'd2);
        chk("R7", "nmi vec", 32'(take_vec), 32'h8);
        cycle("R6");
        nmi_req = 0;
        wr_reg(3, 32'd0, "R6");

        // R9: accept line 3 (prio 9), equal priority cannot preempt, lower can
        ack("R9");
        chk("R9", "active exc", 32'(active_exc), 32'd19);
        cycle("R9");
        wr_reg(4 + 5, 32'd9, "R9");
        #1; chk("R9", "equal no preempt", 32'(take_req), 32'd0);
        cycle("R9");
        wr_reg(4 + 5, 32'd4, "R9");
        #1; chk("R9", "lower preempts", 32'(take_exc), 32'd21);
        ack("R9");
        nmi_req = 1;
        #1; chk("R9", "nmi preempts", 32'(take_exc), 32'd2);
        ack("R9");
        cycle("R9");
        nmi_req = 0;

        // R10, R8: returns restore levels; held line retriggers
        ret("R10");
        chk("R10", "back to line5", 32'(active_exc), 32'd21);
        ret("R10");
        chk("R10", "back to line3", 32'(active_exc), 32'd19);
        #1; chk("R8", "line5 again", 32'(take_exc), 32'd21);
        ret("R10");
        chk("R10", "idle", 32'(active_valid), 32'd0);
        take_ack = 1; ret_pulse = 1;
        cycle("R10");
        chk("R10", "ack with ret ignored", 32'(active_valid), 32'd0);
        ret("R10");

        // R11: fill the nesting stack
        irq_lines = '0;
        wr_reg(1, 32'hFFFF_FFFF, "R11");
        wr_reg(0, 32'hF, "R11");
        wr_reg(4, 32'd8, "R11"); wr_reg(5, 32'd6, "R11");
        wr_reg(6, 32'd4, "R11"); wr_reg(7, 32'd2, "R11");
        irq_lines = N'(32'h1); ack("R11");
        irq_lines = N'(32'h3); ack("R11");
        irq_lines = N'(32'h7); ack("R11");
        irq_lines = N'(32'hF); ack("R11");
        nmi_req = 1;
        #1; chk("R11", "full blocks nmi", 32'(take_req), 32'd0);
        cycle("R11");
        ret("R11");
        #1; chk("R11", "nmi after return", 32'(take_exc), 32'd2);
        nmi_req = 0;
        for (int k = 0; k < 4; k++) ret("R10");

        // R12: unmapped reads
        rd_chk(28, "R12"); rd_chk(31, "R12");

        // random phase
        for (int k = 0; k < 5000; k++) begin
            irq_lines = N'($urandom & $urandom & $urandom);
            nmi_req   = ($urandom % 50) == 0;
            if (($urandom % 4) == 0) begin
                reg_wr    = 1;
                reg_addr  = AW'($urandom % 32);
                reg_wdata = $urandom;
                if (reg_addr == AW'(3) && ($urandom % 2) == 0) reg_wdata[0] = 1'b0;
            end
            take_ack  = ($urandom % 3) == 0;
            ret_pulse = ($urandom % 5) == 0;
            if (($urandom % 6) == 0 && !reg_wr) begin
                int a = int'($urandom % 32);
                rd_chk(a, "R12");
            end
            cycle("R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule